// File: doc/BRIEF.md
# Serial Transmit Frame Closer with Starvation Abort

This block drains a byte-wide transmit FIFO onto a one-bit serial line and decides how each frame ends. The DMA side raises a last-byte indication once it has pushed the final byte of a packet. The closer then reads an empty FIFO in one of two ways.

If the indication has been seen, the empty FIFO marks the end of the frame. CRC accumulation stops and the 32-bit check sequence goes out right behind the data. If the indication has not been seen, the FIFO has run dry in the middle of a packet. The frame is aborted, an underrun status bit is set and an interrupt request may be raised.

A start strobe opens each frame. Bytes are taken from a show-ahead FIFO, where the data port is valid whenever the empty flag is low and a read pulse pops one byte. Each byte is fetched while the last bit of the previous byte is still on the line, so a FIFO that keeps up gives a continuous bit stream.

Top module: `tx_term`

## Requirements
- R1: While reset is held and after it is released, `ser_vld_o`, `fifo_rd_o`, `underrun_o`, `done_o` and `irq_o` are all 0 until the first start strobe.
- R2: Bytes are sent least significant bit first, one bit per cycle, with `ser_vld_o` high for each bit. One FIFO pop delivers the next byte, and the bits run on without a gap while the FIFO is not empty.
- R3: When the FIFO is empty at a byte fetch and the last-byte indication is held, 32 check bits follow the final data bit with no gap. They carry the IEEE 802.3 CRC-32 over the data bits in line order: polynomial 0x04C11DB7, register preset to all ones, complement of the register sent, register bit 31 first. No FIFO pop occurs while they are sent.
- R4: After the final check bit, `done_o` goes to 1 and `ser_vld_o` to 0. `done_o` and `underrun_o` are never 1 together.
- R5: When the FIFO is empty at a byte fetch and the last-byte indication is not held, the byte being shifted finishes and the frame stops. No check bits are sent, `underrun_o` goes to 1 and `done_o` stays 0. A frame that starts with an empty FIFO and no indication aborts with zero bits.
- R6: An abort raises `irq_o` for exactly one cycle, together with the rise of `underrun_o`, when `irq_en_i` was 1 in the abort cycle. `irq_o` stays 0 when `irq_en_i` was 0 and on normal completion.
- R7: A start strobe accepted while idle clears `underrun_o`, `done_o` and any held last-byte indication. A `last_i` pulse in the same cycle as that strobe is kept.
- R8: A start strobe while a frame is being sent is ignored, and the frame's bits and ending are unchanged.
- R9: `fifo_rd_o` is only ever 1 while `fifo_empty_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a frame when idle |
| last_i | input | 1 | DMA has pushed the final byte of the packet |
| irq_en_i | input | 1 | Enables the underrun interrupt |
| fifo_empty_i | input | 1 | Transmit FIFO holds no byte |
| fifo_data_i | input | DATA_W | Head byte of the FIFO (show-ahead) |
| fifo_rd_o | output | 1 | Pops the head byte |
| ser_o | output | 1 | Serial line bit |
| ser_vld_o | output | 1 | `ser_o` carries a frame bit this cycle |
| underrun_o | output | 1 | Last frame was aborted by starvation |
| done_o | output | 1 | Last frame completed with its check bits |
| irq_o | output | 1 | One-cycle underrun interrupt request |

## Verification
The bound checker watches every cycle for the local rules. A pop never happens on an empty FIFO or during the check field. Completion and abort never show together. The interrupt is a single pulse that coincides with the rise of the underrun bit and follows the enable. Only the bench's frames can show the serial content: the bit order, the correct check value, the absence of gaps, the exact bit count before an abort, and the fact that a start strobe in mid-frame changes nothing. The bench compares these against a byte-wise reflected CRC-32 model of its own.

// File: rtl/tx_term_pkg.sv
package tx_term_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CRC  = 2'd2
    } state_e;

    localparam int unsigned DEF_CRC_W    = 32;
    localparam logic [31:0] DEF_CRC_POLY = 32'h04C11DB7;
endpackage

// File: rtl/tx_term_crc.sv
module tx_term_crc #(
    parameter int unsigned   W    = 32,
    parameter logic [W-1:0]  POLY = 32'h04C11DB7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic acc_i,
    input  logic bit_i,
    input  logic shift_i,
    output logic out_o
);
    logic [W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init_i) begin
            crc_d = '1;
        end else if (acc_i) begin
            crc_d = {crc_q[W-2:0], 1'b0} ^ ((crc_q[W-1] ^ bit_i) ? POLY : '0);
        end else if (shift_i) begin
            crc_d = {crc_q[W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign out_o = ~crc_q[W-1];
endmodule

// File: rtl/tx_term_ser.sv
module tx_term_ser #(
    parameter int unsigned DW = 8,
    localparam int unsigned CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    input  logic          shift_i,
    output logic          bit_o,
    output logic [CW-1:0] left_o
);
    typedef struct packed {
        logic [DW-1:0] sr;
        logic [CW-1:0] left;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.sr   = data_i;
            s_d.left = CW'(DW);
        end else if (shift_i && s_q.left != '0) begin
            s_d.sr   = {1'b0, s_q.sr[DW-1:1]};
            s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_o  = s_q.sr[0];
    assign left_o = s_q.left;
endmodule

// File: rtl/tx_term.sv
module tx_term
    import tx_term_pkg::*;
#(
    parameter int unsigned       DATA_W   = 8,
    parameter int unsigned       CRC_W    = DEF_CRC_W,
    parameter logic [CRC_W-1:0]  CRC_POLY = DEF_CRC_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              last_i,
    input  logic              irq_en_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              fifo_rd_o,
    output logic              ser_o,
    output logic              ser_vld_o,
    output logic              underrun_o,
    output logic              done_o,
    output logic              irq_o
);
    localparam int unsigned CNT_W = $clog2(CRC_W);
    localparam int unsigned SH_W  = $clog2(DATA_W + 1);

    typedef struct packed {
        state_e           state;
        logic             last;
        logic             underrun;
        logic             done;
        logic             irq;
        logic [CNT_W-1:0] crc_cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic            sh_load, sh_shift, sh_bit;
    logic [SH_W-1:0] sh_left;
    logic            crc_init, crc_acc, crc_shift, crc_bit;
    logic            bit_avail, need_byte;

    assign bit_avail = (sh_left != '0);
    assign need_byte = (sh_left <= SH_W'(1));

    tx_term_ser #(.DW(DATA_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .data_i  (fifo_data_i),
        .shift_i (sh_shift),
        .bit_o   (sh_bit),
        .left_o  (sh_left)
    );

    tx_term_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (crc_init),
        .acc_i   (crc_acc),
        .bit_i   (sh_bit),
        .shift_i (crc_shift),
        .out_o   (crc_bit)
    );

    always_comb begin
        r_d       = r_q;
        r_d.irq   = 1'b0;
        r_d.last  = r_q.last | last_i;
        fifo_rd_o = 1'b0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        crc_init  = 1'b0;
        crc_acc   = 1'b0;
        crc_shift = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_DATA;
                    r_d.last     = last_i;
                    r_d.underrun = 1'b0;
                    r_d.done     = 1'b0;
                    crc_init     = 1'b1;
                end
            end
            ST_DATA: begin
                sh_shift = bit_avail;
                crc_acc  = bit_avail;
                if (need_byte) begin
                    if (!fifo_empty_i) begin
                        fifo_rd_o = 1'b1;
                        sh_load   = 1'b1;
                    end else if (r_q.last) begin
                        r_d.state   = ST_CRC;
                        r_d.crc_cnt = '0;
                    end else begin
                        r_d.state    = ST_IDLE;
                        r_d.underrun = 1'b1;
                        r_d.irq      = irq_en_i;
                    end
                end
            end
            ST_CRC: begin
                crc_shift = 1'b1;
                if (r_q.crc_cnt == CNT_W'(CRC_W - 1)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.crc_cnt = r_q.crc_cnt + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ser_o      = (r_q.state == ST_CRC) ? crc_bit : sh_bit;
    assign ser_vld_o  = ((r_q.state == ST_DATA) && bit_avail) || (r_q.state == ST_CRC);
    assign underrun_o = r_q.underrun;
    assign done_o     = r_q.done;
    assign irq_o      = r_q.irq;
endmodule

// File: rtl/tx_term_chk.sv
module tx_term_chk (
    input logic clk,
    input logic rst_n,
    input logic fifo_empty_i,
    input logic fifo_rd_o,
    input logic irq_en_i,
    input logic irq_o,
    input logic underrun_o,
    input logic done_o,
    input logic ser_vld_o,
    input logic in_crc
);
    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> !fifo_empty_i);

    assert_no_pop_in_crc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_crc |-> !fifo_rd_o);

    assert_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && underrun_o));

    assert_idle_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !ser_vld_o);

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_with_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $rose(underrun_o));

    assert_irq_when_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(underrun_o) && $past(irq_en_i)) |-> irq_o);

    assert_no_irq_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(underrun_o) && !$past(irq_en_i)) |-> !irq_o);
endmodule

bind tx_term tx_term_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_empty_i (fifo_empty_i),
    .fifo_rd_o    (fifo_rd_o),
    .irq_en_i     (irq_en_i),
    .irq_o        (irq_o),
    .underrun_o   (underrun_o),
    .done_o       (done_o),
    .ser_vld_o    (ser_vld_o),
    .in_crc       (r_q.state == tx_term_pkg::ST_CRC)
);

// File: tb/test_tx_term.sv
module test_tx_term;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       last_i = 1'b0;
    logic       irq_en_i = 1'b0;
    logic       fifo_empty_i;
    logic [7:0] fifo_data_i;
    logic       fifo_rd_o, ser_o, ser_vld_o, underrun_o, done_o, irq_o;

    always #2 clk = ~clk;

    tx_term i_tx_term (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .last_i       (last_i),
        .irq_en_i     (irq_en_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_rd_o    (fifo_rd_o),
        .ser_o        (ser_o),
        .ser_vld_o    (ser_vld_o),
        .underrun_o   (underrun_o),
        .done_o       (done_o),
        .irq_o        (irq_o)
    );

    // bench FIFO model: show-ahead, task writes, always pops
    logic [7:0] mem [256];
    int rd_p = 0;
    int wr_p = 0;
    assign fifo_empty_i = (rd_p == wr_p);
    assign fifo_data_i  = mem[rd_p[7:0]];
    always @(posedge clk) if (fifo_rd_o) rd_p <= rd_p + 1;

    // line monitor
    logic cap_bit [4096];
    int   cap_cyc [4096];
    int   cap_n = 0;
    int   irq_n = 0;
    int   cyc = 0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (ser_vld_o && cap_n < 4096) begin
            cap_bit[cap_n] <= ser_o;
            cap_cyc[cap_n] <= cyc;
            cap_n <= cap_n + 1;
        end
        if (irq_o) irq_n <= irq_n + 1;
    end

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 29 + i * 113 + (i >> 1));
    endfunction

    function automatic logic [31:0] crc_ref(input int base, input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'd0, mem[8'(base + i)]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic run_frame(input int len, input int seed, input bit under,
                             input bit ien, input bit mid, input bit lws);
        int base, s, irq0, nexp, nbits, mism, t;
        logic [31:0] c;
        logic expb;
        @(negedge clk);
        base = wr_p;
        for (int i = 0; i < len; i++) mem[8'(wr_p + i)] = pat(seed, i);
        wr_p = wr_p + len;
        irq_en_i = ien;
        s = cap_n;
        irq0 = irq_n;
        start_i = 1'b1;
        last_i = lws;
        @(negedge clk);
        start_i = 1'b0;
        last_i = !under;
        // R7: status from the previous frame is cleared by the start strobe
        chk(!underrun_o && !done_o, "R7 status cleared on start", {underrun_o, done_o}, 0);
        @(negedge clk);
        last_i = 1'b0;
        if (mid) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1; // R8: ignored while sending
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (!(done_o || underrun_o) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        nexp  = under ? 8 * len : 8 * len + 32;
        nbits = cap_n - s;
        chk(nbits == nexp, under ? "R5 bit count before abort" : "R3 bit count with check field",
            nbits, nexp);
        c = crc_ref(base, len);
        mism = 0;
        for (int k = 0; k < nbits && k < nexp; k++) begin
            if (k < 8 * len) expb = mem[8'(base + k / 8)][k % 8];
            else             expb = c[k - 8 * len];
            if (cap_bit[s + k] !== expb) mism++;
        end
        chk(mism == 0, under ? "R2 data bits LSB first" : "R2/R3 data and check bits", mism, 0);
        if (nbits > 0)
            chk(cap_cyc[s + nbits - 1] - cap_cyc[s] == nbits - 1, "R2 no gap in bit stream",
                cap_cyc[s + nbits - 1] - cap_cyc[s], nbits - 1);
        chk(underrun_o == under, "R5 underrun status", underrun_o, under);
        chk(done_o == !under, "R4 done status", done_o, !under);
        chk(irq_n - irq0 == ((under && ien) ? 1 : 0), "R6 interrupt pulses",
            irq_n - irq0, (under && ien) ? 1 : 0);
        chk(rd_p == wr_p, "R9 all bytes popped", rd_p, wr_p);
        chk(!ser_vld_o, "R4 line idle after frame", ser_vld_o, 0);
    endtask

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] seed;
        logic       under;
        logic       ien;
        logic       mid;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{len: 8'd1,  seed: 8'd3,   under: 1'b0, ien: 1'b1, mid: 1'b0},
        '{len: 8'd4,  seed: 8'd17,  under: 1'b0, ien: 1'b1, mid: 1'b0},
        '{len: 8'd9,  seed: 8'd90,  under: 1'b0, ien: 1'b0, mid: 1'b1},
        '{len: 8'd3,  seed: 8'd5,   under: 1'b1, ien: 1'b1, mid: 1'b0},
        '{len: 8'd6,  seed: 8'd44,  under: 1'b1, ien: 1'b0, mid: 1'b0},
        '{len: 8'd16, seed: 8'd200, under: 1'b0, ien: 1'b1, mid: 1'b1},
        '{len: 8'd12, seed: 8'd61,  under: 1'b1, ien: 1'b1, mid: 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!ser_vld_o && !fifo_rd_o && !underrun_o && !done_o && !irq_o, "R1 outputs in reset",
            {ser_vld_o, fifo_rd_o, underrun_o, done_o, irq_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!ser_vld_o && !fifo_rd_o && !underrun_o && !done_o && !irq_o, "R1 outputs after reset",
            {ser_vld_o, fifo_rd_o, underrun_o, done_o, irq_o}, 0);

        for (int v = 0; v < NV; v++)
            run_frame(int'(VEC[v].len), int'(VEC[v].seed), VEC[v].under, VEC[v].ien, VEC[v].mid, 1'b0);

        // R5: empty FIFO and no last indication at start -> zero-bit abort
        run_frame(0, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        // R7: last pulse together with start is kept -> check field of empty frame
        run_frame(0, 0, 1'b0, 1'b1, 1'b0, 1'b1);
        // R7 after a normal frame, then a one-byte abort
        run_frame(1, 77, 1'b1, 1'b1, 1'b0, 1'b0);
        run_frame(2, 9, 1'b0, 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule